// File: doc/BRIEF.md
# Floppy DMA Request/Acknowledge Handshake

This block sits between the byte-oriented data path of a floppy disk controller and a host DMA engine. When the data path signals that a byte is ready, it raises an active-high request toward the host. The host answers with an active-low acknowledge and, in demand-style transfers where that acknowledge stays low across bytes, with its read strobe. The block recognises the edge that completes a byte, drops the request and hands the data path a one-cycle transfer strobe.

It also watches the host terminal-count line. That line is only honoured while the acknowledge is low, and its active level depends on the operating mode. A sticky flag records that it was seen, and the command sequencer clears that flag with a pulse. Depending on the mode and on a DMA-enable bit, the block either isolates the handshake or keeps it permanently live. When it isolates the handshake, the host inputs are ignored and the request and interrupt pins are released to high impedance, which is expressed here by two output-enable signals.

All host-side inputs pass through a two-stage synchronizer before any edge is detected. An acknowledge or read-strobe edge therefore acts three core clocks after it appears at the port.

Top module: `fdc_dma_handshake`

## Requirements
- R1: When no request is pending and no transfer strobe is active, a high `byte_rdy` sampled at a clock edge drives `drq` high after that edge.
- R2: While `drq` is high, a falling edge of `dack_n` clears `drq` and pulses `xfer_stb` high for exactly one cycle, three clock edges after the edge reaches the port.
- R3: When `dack_n` is already low before `drq` rises, holding it low does not clear `drq`; a falling edge of `rd_n` then clears `drq` and pulses `xfer_stb`, with the same three-edge latency.
- R4: A `byte_rdy` that arrives while `drq` or `xfer_stb` is high is held and re-asserts `drq` on the first edge after `xfer_stb` has dropped. No such pulse is lost.
- R5: Terminal count is accepted only while the qualified acknowledge is low. With `dack_n` high, an active `tc_in` leaves `tc_seen` at 0.
- R6: `mode` encoding is 0 = legacy, 1 = alternate, 2 = extended (3 acts like 0). `tc_in` is active high in legacy and alternate modes and active low in extended mode.
- R7: `tc_seen` sets when an accepted terminal count occurs and stays set until a `tc_clr` pulse. If a set and a clear fall in the same cycle, the set wins.
- R8: In legacy or alternate mode with `dma_en` = 0, `drq_oe` and `irq_oe` go low one edge later, and `dack_n` and `tc_in` have no effect. Setting `dma_en` while `dack_n` is held low is treated as a fresh acknowledge edge.
- R9: In extended mode `drq_oe` and `irq_oe` are high, and the acknowledge and terminal-count paths work, whatever `dma_en` holds.
- R10: During synchronous reset `drq`, `xfer_stb`, `tc_seen`, `drq_oe` and `irq_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_rdy | input | 1 | Data path requests one byte transfer (core domain) |
| dack_n | input | 1 | Host DMA acknowledge, active low (asynchronous) |
| rd_n | input | 1 | Host read strobe, active low (asynchronous) |
| tc_in | input | 1 | Host terminal count, polarity set by mode (asynchronous) |
| mode | input | 2 | 0 legacy, 1 alternate, 2 extended |
| dma_en | input | 1 | DMA enable bit from the drive control register |
| tc_clr | input | 1 | Sequencer pulse that clears `tc_seen` |
| drq | output | 1 | DMA request toward the host, active high |
| xfer_stb | output | 1 | One-cycle strobe: a byte was transferred |
| tc_seen | output | 1 | Sticky terminal-count-seen flag |
| drq_oe | output | 1 | Drive enable for the request pin |
| irq_oe | output | 1 | Drive enable for the interrupt pin |

## Verification
Two functions can fall in the same cycle: completing a byte and requesting the next one. The bench provokes this by raising `byte_rdy` in exactly the cycle in which `xfer_stb` is high. It then expects `drq` to stay low for one more edge and rise on the edge after that. A second collision happens when `dma_en` is raised in legacy mode while `dack_n` and `tc_in` are already held active. On that single edge the bench expects the request to clear, the strobe to fire, `tc_seen` to set and both enables to rise together.

// File: rtl/fdc_dma_pkg.sv
package fdc_dma_pkg;
  typedef enum logic [1:0] {
    MODE_LEGACY = 2'd0,
    MODE_ALT    = 2'd1,
    MODE_EXT    = 2'd2
  } dma_mode_e;

  localparam int HOST_IN_W = 3;  // {tc, rd_n, dack_n}
endpackage

// File: rtl/fdc_dma_sync.sv
module fdc_dma_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fdc_dma_req.sv
module fdc_dma_req (
  input  logic clk,
  input  logic rst,
  input  logic byte_rdy,
  input  logic dack_act,
  input  logic rd_s,
  output logic drq,
  output logic xfer_stb
);
  logic dack_prev, rd_prev, pend;
  logic dack_fall, rd_fall, ack_evt, launch, want;

  assign dack_fall = dack_act & ~dack_prev;
  assign rd_fall   = rd_prev & ~rd_s;
  assign ack_evt   = drq & (dack_fall | (dack_prev & dack_act & rd_fall));
  assign want      = pend | byte_rdy;
  assign launch    = want & ~drq & ~xfer_stb;

  always_ff @(posedge clk) begin
    if (rst) begin
      dack_prev <= 1'b0;
      rd_prev   <= 1'b1;
      pend      <= 1'b0;
      drq       <= 1'b0;
      xfer_stb  <= 1'b0;
    end else begin
      dack_prev <= dack_act;
      rd_prev   <= rd_s;
      pend      <= want & ~launch;
      xfer_stb  <= ack_evt;
      if (launch)       drq <= 1'b1;
      else if (ack_evt) drq <= 1'b0;
    end
  end

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_stb |=> !xfer_stb);
  // R2
  drq_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(drq) |-> xfer_stb);
  // R4
  drq_rise_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(drq) |-> !xfer_stb && !$past(xfer_stb));
endmodule

// File: rtl/fdc_dma_tc.sv
module fdc_dma_tc (
  input  logic clk,
  input  logic rst,
  input  logic tc_s,
  input  logic ext_mode,
  input  logic dack_act,
  input  logic tc_clr,
  output logic tc_seen
);
  logic tc_hit;

  assign tc_hit = dack_act & (ext_mode ? ~tc_s : tc_s);

  always_ff @(posedge clk) begin
    if (rst) tc_seen <= 1'b0;
    else     tc_seen <= tc_hit | (tc_seen & ~tc_clr);
  end

  // R7
  tc_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    tc_seen && !tc_clr |=> tc_seen);
  // R5
  tc_qualified_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tc_seen) |-> $past(dack_act));
endmodule

// File: rtl/fdc_dma_handshake.sv
module fdc_dma_handshake
  import fdc_dma_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_rdy,
  input  logic       dack_n,
  input  logic       rd_n,
  input  logic       tc_in,
  input  logic [1:0] mode,
  input  logic       dma_en,
  input  logic       tc_clr,
  output logic       drq,
  output logic       xfer_stb,
  output logic       tc_seen,
  output logic       drq_oe,
  output logic       irq_oe
);
  localparam logic [HOST_IN_W-1:0] SYNC_RST = 3'b011;

  logic [HOST_IN_W-1:0] host_s;
  logic ext_mode, path_en, dack_act;

  fdc_dma_sync #(.W(HOST_IN_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({tc_in, rd_n, dack_n}),
    .q   (host_s)
  );

  assign ext_mode = (mode == MODE_EXT);
  assign path_en  = ext_mode | dma_en;
  assign dack_act = path_en & ~host_s[0];

  fdc_dma_req u_req (
    .clk      (clk),
    .rst      (rst),
    .byte_rdy (byte_rdy),
    .dack_act (dack_act),
    .rd_s     (host_s[1]),
    .drq      (drq),
    .xfer_stb (xfer_stb)
  );

  fdc_dma_tc u_tc (
    .clk      (clk),
    .rst      (rst),
    .tc_s     (host_s[2]),
    .ext_mode (ext_mode),
    .dack_act (dack_act),
    .tc_clr   (tc_clr),
    .tc_seen  (tc_seen)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      drq_oe <= 1'b0;
      irq_oe <= 1'b0;
    end else begin
      drq_oe <= path_en;
      irq_oe <= path_en;
    end
  end

  // R8
  iso_oe_chk: assert property (@(posedge clk) disable iff (rst)
    !path_en |=> !drq_oe && !irq_oe);
  // R9
  ext_live_chk: assert property (@(posedge clk) disable iff (rst)
    ext_mode |=> drq_oe && irq_oe);
endmodule

// File: tb/test_fdc_dma_handshake.sv
module test_fdc_dma_handshake;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, byte_rdy, dack_n, rd_n, tc_in, dma_en, tc_clr;
  logic [1:0] mode;
  logic drq, xfer_stb, tc_seen, drq_oe, irq_oe;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  string qtag[$];
  logic [4:0] qval[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fdc_dma_handshake i_fdc_dma_handshake (
    .clk(clk), .rst(rst), .byte_rdy(byte_rdy), .dack_n(dack_n), .rd_n(rd_n),
    .tc_in(tc_in), .mode(mode), .dma_en(dma_en), .tc_clr(tc_clr),
    .drq(drq), .xfer_stb(xfer_stb), .tc_seen(tc_seen),
    .drq_oe(drq_oe), .irq_oe(irq_oe)
  );

  // expected order: {drq, xfer_stb, tc_seen, drq_oe, irq_oe}
  task automatic expect_o(input string tag, input logic [4:0] v);
    qtag.push_back(tag);
    qval.push_back(v);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: compares at the falling edge, away from the active edge
  always @(negedge clk) begin
    while (qval.size() > 0) begin
      string t;
      logic [4:0] e, a;
      t = qtag.pop_front();
      e = qval.pop_front();
      a = {drq, xfer_stb, tc_seen, drq_oe, irq_oe};
      tests++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: got %b expected %b", t, a, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; byte_rdy = 0; dack_n = 1; rd_n = 1; tc_in = 0;
    mode = 2'd0; dma_en = 1; tc_clr = 0;
    cyc(1);
    expect_o("R10 reset", 5'b00000);
    cyc(2);
    rst = 0;
    cyc(1);
    expect_o("R10 after reset", 5'b00011);

    // R1 request, R2 single-byte acknowledge
    byte_rdy = 1; cyc(1); byte_rdy = 0;
    expect_o("R1 request", 5'b10011);
    dack_n = 0; cyc(2);
    expect_o("R2 sync latency", 5'b10011);
    cyc(1);
    expect_o("R2 clear+strobe", 5'b01011);
    cyc(1);
    expect_o("R2 strobe one cycle", 5'b00011);
    dack_n = 1; cyc(4);

    // R4 byte ready coincides with strobe
    byte_rdy = 1; cyc(1); byte_rdy = 0;
    dack_n = 0; cyc(3);
    byte_rdy = 1;
    expect_o("R2 strobe", 5'b01011);
    cyc(1); byte_rdy = 0;
    expect_o("R4 held during strobe", 5'b00011);
    cyc(1);
    expect_o("R4 relaunch", 5'b10011);

    // R3 demand mode: acknowledge already low
    cyc(5);
    expect_o("R3 held ack no clear", 5'b10011);
    rd_n = 0; cyc(3);
    expect_o("R3 read strobe clears", 5'b01011);
    rd_n = 1; cyc(1);
    expect_o("R3 strobe ends", 5'b00011);
    cyc(3);

    // R6 legacy polarity, R7 sticky flag
    byte_rdy = 1; cyc(1); byte_rdy = 0;
    expect_o("R1 demand request", 5'b10011);
    tc_in = 1; cyc(2);
    expect_o("R6 tc latency", 5'b10011);
    cyc(1);
    expect_o("R6 legacy tc high", 5'b10111);
    tc_in = 0; cyc(4);
    expect_o("R7 sticky", 5'b10111);
    tc_clr = 1; cyc(1); tc_clr = 0;
    expect_o("R7 cleared", 5'b10011);

    // R5 tc with ack high ignored
    dack_n = 1; cyc(4);
    tc_in = 1; cyc(5);
    expect_o("R5 tc without ack", 5'b10011);
    tc_in = 0; cyc(3);

    // alternate mode: active-high tc
    mode = 2'd1;
    dack_n = 0; cyc(3);
    expect_o("R2 alt mode ack", 5'b01011);
    tc_in = 1; cyc(3);
    expect_o("R6 alt tc high", 5'b00111);
    tc_in = 0; cyc(3);
    tc_clr = 1; cyc(1); tc_clr = 0;
    expect_o("R7 alt clear", 5'b00011);

    // extended mode: active-low tc (tc_in already low, ack low)
    mode = 2'd2; cyc(1);
    expect_o("R6 ext tc low", 5'b00111);
    tc_in = 1; cyc(3);
    tc_clr = 1; cyc(1); tc_clr = 0;
    expect_o("R7 ext clear", 5'b00011);
    cyc(3);
    expect_o("R6 ext tc high inactive", 5'b00011);

    // R9 extended ignores dma_en
    dma_en = 0; cyc(1);
    expect_o("R9 oe kept", 5'b00011);
    dack_n = 1; cyc(3);
    byte_rdy = 1; cyc(1); byte_rdy = 0;
    expect_o("R9 request", 5'b10011);
    dack_n = 0; cyc(3);
    expect_o("R9 ack works", 5'b01011);
    dack_n = 1; tc_in = 0; cyc(3);

    // R8 legacy with dma_en = 0
    mode = 2'd0; cyc(1);
    expect_o("R8 oe released", 5'b00000);
    byte_rdy = 1; cyc(1); byte_rdy = 0;
    expect_o("R8 internal request", 5'b10000);
    dack_n = 0; tc_in = 1; cyc(5);
    expect_o("R8 ack and tc ignored", 5'b10000);
    dma_en = 1; cyc(1);
    expect_o("R8 enable with ack held", 5'b01111);
    cyc(1);
    expect_o("R8 strobe ends", 5'b00111);

    cyc(2);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule